// File: doc/BRIEF.md
# Key-Protected System Control Register Bank

This block is a small bank of chip-level control registers on a plain 32-bit register bus. The bus carries a word address, write data, byte strobes and a write flag. Reads return data one cycle after the request. Most of the bank is guarded by a protection key. Software unlocks the bank by writing a magic value to the key register, and locks it again by writing any other value, normally the bitwise inverse of the magic value. The key register never holds or returns the magic value. It reads back only as a 0/1 open flag.

The bank also holds a board strap word, which is loaded from the strap input pins during reset. At run time it changes only through two separate addresses: one where written ones set strap bits, and one where written ones clear strap bits. The clear address reads back a fixed revision code, which writes never change. Two identification words report a silicon revision code chosen by a revision input. A set of scratch words acts as ordinary storage while the bank is open. Reads may use 1, 2 or 4 byte lanes. Writes must use all four lanes.

Top module: `sysctl_regbank`

## Requirements
- R1: During reset the strap word loads from `strap_i`, every scratch word clears to zero, and the key register (word 0) takes the value of `preunlock_i`: 1 means open, 0 means locked.
- R2: A full-width write to word 0 with data equal to the `KEY_MAGIC` parameter (default 0x1688A8A8) makes the next read of word 0 return 1. A full-width write of any other value makes the next read return 0.
- R3: While word 0 reads 0, writes to the strap set word (3), the strap clear word (4) and the scratch words (5 to 5+NUM_SCRATCH-1) are discarded. While it reads 1, writes to the scratch words are stored and read back unchanged.
- R4: Writing the bitwise inverse of the magic value to word 0 locks the bank, and the very next read of word 0 returns 0.
- R5: While the bank is open, each 1 bit written to word 3 sets that strap bit and each 0 bit leaves it unchanged. Word 3 reads back the strap word.
- R6: While the bank is open, each 1 bit written to word 4 clears that strap bit. Word 4 always reads the revision code of word 2, and writes never alter that code.
- R7: Word 1 always reads `ID_EARLY` (default 0x05010303). Word 2 reads `ID_LATE` (default 0x05020303) when `silicon_rev_late_i` is 1, and `ID_EARLY` when it is 0.
- R8: Read data appears on `rsp_rdata_o` in the cycle after the request. Byte lanes whose strobe is 0 read as zero. The legal read strobes are 0001, 0010, 0100, 1000, 0011, 1100 and 1111. Any other strobe pattern reads all zeros.
- R9: A write whose strobe is not 1111 is ignored at every address, including the key register.
- R10: An access to a word outside 0 to 4+NUM_SCRATCH reads zero and changes nothing. It raises `rsp_err_o` for exactly the one cycle after the request.
- R11: The strap word can be read at word 3 whether the bank is locked or open.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| preunlock_i | input | 1 | Sampled during reset; 1 makes the bank come out of reset open |
| silicon_rev_late_i | input | 1 | Selects the later silicon revision code for word 2 |
| strap_i | input | 32 | Board strap pins, loaded during reset |
| req_valid_i | input | 1 | Access request this cycle |
| req_write_i | input | 1 | 1 for a write, 0 for a read |
| req_addr_i | input | ADDR_W | Word address |
| req_be_i | input | 4 | Byte strobes |
| req_wdata_i | input | 32 | Write data |
| rsp_rdata_o | output | 32 | Read data, registered, held until the next read |
| rsp_err_o | output | 1 | One-cycle pulse after an access to an unmapped word |

## Verification
Assertions run on every cycle and check the following:
- the key state changes only on a full-width key write, and it then equals the result of comparing the written data with the magic value;
- the strap word stays stable when neither strap address is written, shows every set bit after a set write, and shows every cleared bit after a clear write;
- the scratch words hold their values while the bank is locked;
- an error pulse always follows a request, and an unmapped read returns zero with it.

Only the directed scenarios can show some behaviours. These include the read-back encodings of the key register, the lock taking effect on the very next read, the lane masking and illegal read strobes, and the revision-dependent identification codes. They also include the open state when the bank comes out of reset with `preunlock_i` set.

// File: rtl/sysctl_pkg.sv
// Shared constants, register selector type and lane helpers for the
// system control register bank. Assumes a 32-bit data path with byte strobes.
package sysctl_pkg;

    localparam int DATA_W = 32;
    localparam int BE_W   = DATA_W / 8;

    // Which register an access selects after address decode.
    typedef enum logic [2:0] {
        SEL_KEY,
        SEL_ID_A,
        SEL_ID_B,
        SEL_STRAP_SET,
        SEL_STRAP_CLR,
        SEL_SCRATCH,
        SEL_NONE
    } reg_sel_e;

    // Expand byte strobes to a bit mask.
    function automatic logic [DATA_W-1:0] lane_mask(input logic [BE_W-1:0] be);
        logic [DATA_W-1:0] m;
        for (int i = 0; i < BE_W; i++) begin
            m[i*8 +: 8] = {8{be[i]}};
        end
        return m;
    endfunction

    // True for naturally aligned 1, 2 or 4 byte read strobes.
    function automatic logic read_be_ok(input logic [BE_W-1:0] be);
        case (be)
            4'b0001, 4'b0010, 4'b0100, 4'b1000,
            4'b0011, 4'b1100, 4'b1111: return 1'b1;
            default:                   return 1'b0;
        endcase
    endfunction

endpackage

// File: rtl/sysctl_decode.sv
// Address decoder: maps a word address to a register selector and, for the
// scratch range, a scratch index. Purely combinational; the fixed registers
// sit at words 0..4 and the scratch words start at word 5.
module sysctl_decode
    import sysctl_pkg::*;
#(
    parameter int ADDR_W      = 6,
    parameter int NUM_SCRATCH = 4,
    parameter int IDX_W       = 2
) (
    input  logic [ADDR_W-1:0] addr_i,
    output reg_sel_e          sel_o,
    output logic [IDX_W-1:0]  idx_o
);

    localparam logic [ADDR_W-1:0] W_KEY     = ADDR_W'(0);
    localparam logic [ADDR_W-1:0] W_ID_A    = ADDR_W'(1);
    localparam logic [ADDR_W-1:0] W_ID_B    = ADDR_W'(2);
    localparam logic [ADDR_W-1:0] W_SET     = ADDR_W'(3);
    localparam logic [ADDR_W-1:0] W_CLR     = ADDR_W'(4);
    localparam logic [ADDR_W-1:0] W_SCR0    = ADDR_W'(5);
    localparam logic [ADDR_W-1:0] W_SCR_END = ADDR_W'(5 + NUM_SCRATCH);

    logic [ADDR_W-1:0] offset;

    // Decode the word address into a selector and scratch index.
    always_comb begin
        offset = addr_i - W_SCR0;
        idx_o  = offset[IDX_W-1:0];
        if (addr_i == W_KEY)                            sel_o = SEL_KEY;
        else if (addr_i == W_ID_A)                      sel_o = SEL_ID_A;
        else if (addr_i == W_ID_B)                      sel_o = SEL_ID_B;
        else if (addr_i == W_SET)                       sel_o = SEL_STRAP_SET;
        else if (addr_i == W_CLR)                       sel_o = SEL_STRAP_CLR;
        else if (addr_i >= W_SCR0 && addr_i < W_SCR_END) sel_o = SEL_SCRATCH;
        else                                            sel_o = SEL_NONE;
    end

endmodule

// File: rtl/sysctl_key_guard.sv
// Protection key state: a single open flag. A full-width key write compares
// its data with the magic value and stores only the result. Reset loads the
// preunlock input. Assumes the caller gates key_wr_i with full strobes.
module sysctl_key_guard
    import sysctl_pkg::*;
#(
    parameter logic [DATA_W-1:0] KEY_MAGIC = 32'h1688_A8A8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              preunlock_i,
    input  logic              key_wr_i,
    input  logic [DATA_W-1:0] wdata_i,
    output logic              open_o
);

    // Hold the open flag; update it only on a key write.
    always_ff @(posedge clk) begin
        if (!rst_n)        open_o <= preunlock_i;
        else if (key_wr_i) open_o <= (wdata_i == KEY_MAGIC);
    end

    // R2: after a key write the flag reflects the magic comparison
    p_key_result_r2: assert property (@(posedge clk) disable iff (!rst_n)
        key_wr_i |=> (open_o == ($past(wdata_i) == KEY_MAGIC)));

    // R2: without a key write the flag does not move
    p_key_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !key_wr_i |=> $stable(open_o));

endmodule

// File: rtl/sysctl_strap_reg.sv
// Strap word: loaded from the strap pins during reset, then modified only by
// write-1-to-set and write-1-to-clear strobes. Assumes set and clear enables
// are already qualified by the lock and full-width checks.
module sysctl_strap_reg
    import sysctl_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DATA_W-1:0] strap_i,
    input  logic              set_en_i,
    input  logic              clr_en_i,
    input  logic [DATA_W-1:0] wdata_i,
    output logic [DATA_W-1:0] strap_o
);

    // Load the pins at reset; set or clear written-one bits afterwards.
    always_ff @(posedge clk) begin
        if (!rst_n)        strap_o <= strap_i;
        else if (set_en_i) strap_o <= strap_o | wdata_i;
        else if (clr_en_i) strap_o <= strap_o & ~wdata_i;
    end

    // R5: every written one is set after a set write
    p_strap_set_r5: assert property (@(posedge clk) disable iff (!rst_n)
        set_en_i |=> ((strap_o & $past(wdata_i)) == $past(wdata_i)));

    // R6: every written one is cleared after a clear write
    p_strap_clr_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_en_i && !set_en_i) |=> ((strap_o & $past(wdata_i)) == '0));

    // R3: the strap word is stable when neither strap address is written
    p_strap_idle_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!set_en_i && !clr_en_i) |=> $stable(strap_o));

endmodule

// File: rtl/sysctl_scratch_file.sv
// Scratch words: plain storage, one register per word, written only when
// the write enable (already lock-qualified) targets that index. Read is a
// combinational index mux. Assumes NUM_SCRATCH fits in IDX_W bits.
module sysctl_scratch_file
    import sysctl_pkg::*;
#(
    parameter int NUM_SCRATCH = 4,
    parameter int IDX_W       = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              open_i,
    input  logic              wr_en_i,
    input  logic [IDX_W-1:0]  idx_i,
    input  logic [DATA_W-1:0] wdata_i,
    output logic [DATA_W-1:0] rdata_o
);

    logic [DATA_W-1:0] word_q [NUM_SCRATCH];

    for (genvar g = 0; g < NUM_SCRATCH; g++) begin : g_word
        // Store one scratch word when it is the write target.
        always_ff @(posedge clk) begin
            if (!rst_n)                                   word_q[g] <= '0;
            else if (wr_en_i && idx_i == IDX_W'(g))       word_q[g] <= wdata_i;
        end

        // R3: a locked bank leaves every scratch word unchanged
        p_locked_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
            !open_i |=> $stable(word_q[g]));
    end

    // Select the addressed scratch word for reads.
    always_comb begin
        rdata_o = word_q[idx_i];
    end

endmodule

// File: rtl/sysctl_regbank.sv
// Top of the key-protected system control register bank. Decodes each bus
// access, qualifies writes by full strobes and the lock, and registers the
// read data and the unmapped-access error pulse. Assumes one access per
// cycle and a word-addressed bus.
module sysctl_regbank
    import sysctl_pkg::*;
#(
    parameter int                ADDR_W      = 6,
    parameter int                NUM_SCRATCH = 4,
    parameter logic [DATA_W-1:0] KEY_MAGIC   = 32'h1688_A8A8,
    parameter logic [DATA_W-1:0] ID_EARLY    = 32'h0501_0303,
    parameter logic [DATA_W-1:0] ID_LATE     = 32'h0502_0303
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              preunlock_i,
    input  logic              silicon_rev_late_i,
    input  logic [31:0]       strap_i,
    input  logic              req_valid_i,
    input  logic              req_write_i,
    input  logic [ADDR_W-1:0] req_addr_i,
    input  logic [3:0]        req_be_i,
    input  logic [31:0]       req_wdata_i,
    output logic [31:0]       rsp_rdata_o,
    output logic              rsp_err_o
);

    localparam int IDX_W = (NUM_SCRATCH > 1) ? $clog2(NUM_SCRATCH) : 1;

    reg_sel_e          sel;
    logic [IDX_W-1:0]  scr_idx;
    logic              wr_full;
    logic              key_wr;
    logic              prot_wr;
    logic              is_open;
    logic [DATA_W-1:0] strap_q;
    logic [DATA_W-1:0] scr_rdata;
    logic [DATA_W-1:0] id_b_val;
    logic [DATA_W-1:0] raw_rdata;
    logic [DATA_W-1:0] rd_next;

    sysctl_decode #(
        .ADDR_W(ADDR_W), .NUM_SCRATCH(NUM_SCRATCH), .IDX_W(IDX_W)
    ) i_decode (
        .addr_i(req_addr_i), .sel_o(sel), .idx_o(scr_idx)
    );

    // Qualify writes: full strobes for all, the open flag for protected words.
    always_comb begin
        wr_full = req_valid_i && req_write_i && (req_be_i == 4'hF);
        key_wr  = wr_full && (sel == SEL_KEY);
        prot_wr = wr_full && is_open;
    end

    sysctl_key_guard #(.KEY_MAGIC(KEY_MAGIC)) i_key (
        .clk(clk), .rst_n(rst_n), .preunlock_i(preunlock_i),
        .key_wr_i(key_wr), .wdata_i(req_wdata_i), .open_o(is_open)
    );

    sysctl_strap_reg i_strap (
        .clk(clk), .rst_n(rst_n), .strap_i(strap_i),
        .set_en_i(prot_wr && sel == SEL_STRAP_SET),
        .clr_en_i(prot_wr && sel == SEL_STRAP_CLR),
        .wdata_i(req_wdata_i), .strap_o(strap_q)
    );

    sysctl_scratch_file #(.NUM_SCRATCH(NUM_SCRATCH), .IDX_W(IDX_W)) i_scratch (
        .clk(clk), .rst_n(rst_n), .open_i(is_open),
        .wr_en_i(prot_wr && sel == SEL_SCRATCH),
        .idx_i(scr_idx), .wdata_i(req_wdata_i), .rdata_o(scr_rdata)
    );

    // Choose the read value and apply lane masking.
    always_comb begin
        id_b_val = silicon_rev_late_i ? ID_LATE : ID_EARLY;
        case (sel)
            SEL_KEY:       raw_rdata = {{(DATA_W-1){1'b0}}, is_open};
            SEL_ID_A:      raw_rdata = ID_EARLY;
            SEL_ID_B:      raw_rdata = id_b_val;
            SEL_STRAP_SET: raw_rdata = strap_q;
            SEL_STRAP_CLR: raw_rdata = id_b_val;
            SEL_SCRATCH:   raw_rdata = scr_rdata;
            default:       raw_rdata = '0;
        endcase
        rd_next = read_be_ok(req_be_i) ? (raw_rdata & lane_mask(req_be_i)) : '0;
    end

    // Register read data on reads and the error flag on every access.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_rdata_o <= '0;
            rsp_err_o   <= 1'b0;
        end else begin
            if (req_valid_i && !req_write_i) rsp_rdata_o <= rd_next;
            rsp_err_o <= req_valid_i && (sel == SEL_NONE);
        end
    end

    // R10: the error pulse only follows a request
    p_err_after_req_r10: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_err_o |-> $past(req_valid_i));

    // R10: an unmapped read returns zero alongside its error pulse
    p_unmapped_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_err_o && !$past(req_write_i)) |-> (rsp_rdata_o == '0));

    // R9: a partial write never changes the open flag
    p_partial_key_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid_i && req_write_i && req_be_i != 4'hF) |=> $stable(is_open));

endmodule

// File: tb/test_sysctl_regbank.sv
// Directed bench for the key-protected control register bank.
module test_sysctl_regbank;

    localparam int          ADDR_W = 6;
    localparam logic [31:0] MAGIC  = 32'h1688_A8A8;
    localparam logic [31:0] EARLY  = 32'h0501_0303;
    localparam logic [31:0] LATE   = 32'h0502_0303;
    localparam logic [31:0] STRAPS = 32'hA5A5_0F0F;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              preunlock = 1'b0;
    logic              rev_late = 1'b0;
    logic [31:0]       strap_pins = STRAPS;
    logic              req_valid = 1'b0;
    logic              req_write = 1'b0;
    logic [ADDR_W-1:0] req_addr = '0;
    logic [3:0]        req_be = 4'hF;
    logic [31:0]       req_wdata = '0;
    logic [31:0]       rsp_rdata;
    logic              rsp_err;

    int checks = 0;
    int errors = 0;
    int cycles = 0;

    always #10 clk = ~clk;

    sysctl_regbank i_sysctl_regbank (
        .clk(clk), .rst_n(rst_n), .preunlock_i(preunlock),
        .silicon_rev_late_i(rev_late), .strap_i(strap_pins),
        .req_valid_i(req_valid), .req_write_i(req_write), .req_addr_i(req_addr),
        .req_be_i(req_be), .req_wdata_i(req_wdata),
        .rsp_rdata_o(rsp_rdata), .rsp_err_o(rsp_err)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic do_reset(input logic pre);
        preunlock = pre;
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic bus_write(input int addr, input logic [3:0] be, input logic [31:0] d,
                             output logic err);
        req_valid = 1'b1; req_write = 1'b1; req_addr = ADDR_W'(addr);
        req_be = be; req_wdata = d;
        @(negedge clk);
        req_valid = 1'b0; req_write = 1'b0;
        err = rsp_err;
    endtask

    task automatic bus_read(input int addr, input logic [3:0] be,
                            output logic [31:0] d, output logic err);
        req_valid = 1'b1; req_write = 1'b0; req_addr = ADDR_W'(addr); req_be = be;
        @(negedge clk);
        req_valid = 1'b0;
        d = rsp_rdata; err = rsp_err;
    endtask

    task automatic t_reset_state();
        logic [31:0] d; logic e;
        check("R1 rdata after reset", rsp_rdata, 32'h0);
        bus_read(0, 4'hF, d, e); check("R1 key locked at reset", d, 32'h0);
        bus_read(5, 4'hF, d, e); check("R1 scratch zero at reset", d, 32'h0);
        bus_read(3, 4'hF, d, e); check("R1 R11 strap loaded", d, STRAPS);
    endtask

    task automatic t_locked_writes();
        logic [31:0] d; logic e;
        bus_write(5, 4'hF, 32'hDEAD_BEEF, e);
        bus_read(5, 4'hF, d, e); check("R3 locked scratch write dropped", d, 32'h0);
        bus_write(3, 4'hF, 32'hFFFF_FFFF, e);
        bus_write(4, 4'hF, 32'hFFFF_FFFF, e);
        bus_read(3, 4'hF, d, e); check("R3 R11 locked strap write dropped", d, STRAPS);
    endtask

    task automatic t_key_unlock();
        logic [31:0] d; logic e;
        bus_write(0, 4'hF, 32'h1234_5678, e);
        bus_read(0, 4'hF, d, e); check("R2 wrong key reads 0", d, 32'h0);
        bus_write(0, 4'hF, MAGIC, e);
        bus_read(0, 4'hF, d, e); check("R2 magic key reads 1", d, 32'h1);
    endtask

    task automatic t_scratch();
        logic [31:0] d; logic e;
        bus_write(5, 4'hF, 32'hCAFE_F00D, e);
        bus_write(8, 4'hF, 32'h0F1E_2D3C, e);
        bus_read(5, 4'hF, d, e); check("R3 scratch0 stored", d, 32'hCAFE_F00D);
        bus_read(8, 4'hF, d, e); check("R3 scratch3 stored", d, 32'h0F1E_2D3C);
    endtask

    task automatic t_strap();
        logic [31:0] d; logic e;
        bus_write(3, 4'hF, 32'h0000_F000, e);
        bus_read(3, 4'hF, d, e); check("R5 w1s", d, 32'hA5A5_FF0F);
        bus_write(4, 4'hF, 32'hA000_000F, e);
        bus_read(3, 4'hF, d, e); check("R6 w1c", d, 32'h05A5_FF00);
        bus_read(4, 4'hF, d, e); check("R6 revision code unchanged", d, EARLY);
    endtask

    task automatic t_ids();
        logic [31:0] d; logic e;
        rev_late = 1'b0;
        bus_read(1, 4'hF, d, e); check("R7 id_a early rev", d, EARLY);
        bus_read(2, 4'hF, d, e); check("R7 id_b early rev", d, EARLY);
        rev_late = 1'b1;
        bus_read(1, 4'hF, d, e); check("R7 id_a late rev", d, EARLY);
        bus_read(2, 4'hF, d, e); check("R7 id_b late rev", d, LATE);
        bus_read(4, 4'hF, d, e); check("R6 R7 revision word late", d, LATE);
    endtask

    task automatic t_lanes();
        logic [31:0] d; logic e;
        bus_read(5, 4'b0010, d, e); check("R8 byte1 read", d, 32'h0000_F000);
        bus_read(5, 4'b1100, d, e); check("R8 upper half read", d, 32'hCAFE_0000);
        bus_read(5, 4'b0101, d, e); check("R8 illegal strobe zero", d, 32'h0);
    endtask

    task automatic t_partial_write();
        logic [31:0] d; logic e;
        bus_write(5, 4'b0011, 32'h1111_1111, e);
        bus_read(5, 4'hF, d, e); check("R9 partial scratch write ignored", d, 32'hCAFE_F00D);
        bus_write(0, 4'b0001, 32'h0, e);
        bus_read(0, 4'hF, d, e); check("R9 partial key write ignored", d, 32'h1);
    endtask

    task automatic t_unmapped();
        logic [31:0] d; logic e;
        bus_read(40, 4'hF, d, e);
        check("R10 unmapped read zero", d, 32'h0);
        check("R10 unmapped read err", {31'b0, e}, 32'h1);
        @(negedge clk);
        check("R10 err one cycle", {31'b0, rsp_err}, 32'h0);
        bus_write(9, 4'hF, 32'h5555_5555, e);
        check("R10 unmapped write err", {31'b0, e}, 32'h1);
        bus_read(5, 4'hF, d, e);
        check("R10 mapped access no err", {31'b0, e}, 32'h0);
        check("R10 unmapped write changed nothing", d, 32'hCAFE_F00D);
    endtask

    task automatic t_relock();
        logic [31:0] d; logic e;
        bus_write(0, 4'hF, ~MAGIC, e);
        bus_read(0, 4'hF, d, e); check("R4 inverse magic relocks at once", d, 32'h0);
        bus_write(6, 4'hF, 32'h7777_7777, e);
        bus_read(6, 4'hF, d, e); check("R3 R4 relocked scratch write dropped", d, 32'h0);
        bus_read(3, 4'b0011, d, e); check("R11 strap readable locked", d, 32'h0000_FF00);
    endtask

    task automatic t_preunlock();
        logic [31:0] d; logic e;
        strap_pins = 32'h0000_0042;
        do_reset(1'b1);
        bus_read(0, 4'hF, d, e); check("R1 preunlock reset open", d, 32'h1);
        bus_read(3, 4'hF, d, e); check("R1 strap reloaded", d, 32'h0000_0042);
        bus_write(7, 4'hF, 32'h0BAD_CAFE, e);
        bus_read(7, 4'hF, d, e); check("R1 R3 open after preunlock", d, 32'h0BAD_CAFE);
    endtask

    task automatic finish_run();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 20000) begin
            checks++; errors++;
            $display("FAIL watchdog: actual=%0d expected<=20000 cycles", cycles);
            finish_run();
        end
    end

    initial begin
        do_reset(1'b0);
        t_reset_state();
        t_locked_writes();
        t_key_unlock();
        t_scratch();
        t_strap();
        t_ids();
        t_lanes();
        t_partial_write();
        t_unmapped();
        t_relock();
        t_preunlock();
        finish_run();
    end

endmodule